// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave-side command engine of a small serial EEPROM with a 256-byte array. It watches chip select, serial clock and serial data in, all sampled by the system clock. It collects an 8-bit command, then a byte address and data, and drives serial data out for array and status reads. Six commands are decoded: array read, status read, byte/page write, status write, and the two commands that set and clear the write-enable latch.

Write-type commands are held in a buffer. They take effect only if chip select rises inside a narrow window that depends on the command. If chip select rises anywhere else, the command is dropped. Once a write has been committed, a self-timed write cycle runs for a fixed number of system clocks, and nothing on the serial pins can stop it. The array or the status bits change at the end of that cycle.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Serial data in is captured MSB first on SCK rising edges while CS_n is low. Read data goes out MSB first and changes after SCK falling edges. `so` is 0 whenever CS_n is high.
- R2: Array read (command 0x03) is followed by one address byte. It returns the addressed byte and then the following bytes, wrapping from 0xFF to 0x00. Raising CS_n at any point ends the read, and no state changes.
- R3: Status read (command 0x05) returns the status byte, repeated for every further byte while CS_n stays low. Status bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are user bits.
- R4: Enable (first seven command bits 0000011) sets the latch. Disable (first seven bits 0000100) clears it. Either one acts only if CS_n rises after at least seven SCK rising edges; with fewer edges nothing happens.
- R5: Write (command 0x02, address, data) commits only if CS_n rises after one or more whole data bytes and before any further SCK rising edge. Rising at any other point (command, address, bits D7..D1 of a data byte) cancels it, and nothing is written.
- R6: During a page write, the address advances in its low 4 bits only, so it wraps inside a 16-byte page. A later byte for the same location replaces the earlier one.
- R7: Status write (command 0x01) commits only if CS_n rises after exactly 15 SCK rising edges. Data bits D7..D2 become status bits 7..2. Rising after 14 or fewer edges, or after 16 or more, cancels it.
- R8: Write and status write commit only when the latch is 1 and no write cycle is running at the CS_n rise. Otherwise they are ignored.
- R9: From a commit, write-in-progress reads 1 for WR_CYCLES system clocks. When the cycle ends, the array or status bits are updated and the latch is cleared.
- R10: A running write cycle always completes. CS_n and SCK activity, including a new write frame, neither stops it nor changes the data it will store.
- R11: An array read during a write cycle returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |

## Verification
The hardest conditions to reach are the commit windows and the proof that a running write cycle is immune to disturbance. Frames are therefore cut off at exact SCK edge counts: 6 and 7 edges for the latch commands, 14/15/16 for status write, and 23/24/25 and 40 for writes. While a cycle is running, the bench issues a status read, an array read, a full enabled-looking write frame and bare SCK pulses. It then reads the array back after the cycle to show that only the committed data landed.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam int ADDR_BITS = 8;
  localparam int USER_BITS = 6;

  localparam logic [7:0] CMD_STWR  = 8'h01;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_STRD  = 8'h05;
  localparam logic [6:0] EN_PFX    = 7'b0000011;
  localparam logic [6:0] DIS_PFX   = 7'b0000100;

  // whole data bytes received, no extra bit clocked
  function automatic logic wr_window(input logic [1:0] nbytes, input logic [2:0] nbits);
    return (nbytes == 2'd3) && (nbits == 3'd0);
  endfunction

  // exactly fifteen edges: one byte plus seven bits
  function automatic logic st_window(input logic [1:0] nbytes, input logic [2:0] nbits);
    return (nbytes == 2'd1) && (nbits == 3'd7);
  endfunction

  // seven or more edges
  function automatic logic latch_window(input logic [1:0] nbytes, input logic [2:0] nbits);
    return (nbytes != 2'd0) || (nbits == 3'd7);
  endfunction

  function automatic logic [ADDR_BITS-1:0] page_next(input logic [ADDR_BITS-1:0] a,
                                                     input logic [ADDR_BITS-1:0] mask);
    return (a & ~mask) | ((a + 1'b1) & mask);
  endfunction
endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg <= {STAGES{RST}};
    else        stg <= {stg[STAGES-2:0], din};

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/spi_eeprom_frame.sv
module spi_eeprom_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low,
  input  logic       sck_rise,
  input  logic       si_b,
  output logic [1:0] nbytes,
  output logic [2:0] nbits,
  output logic [7:0] opcode,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [6:0] part7
);
  logic [6:0] sr;
  logic [7:0] full;
  assign full  = {sr, si_b};
  assign part7 = sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; nbits <= '0; nbytes <= '0; opcode <= '0;
      byte_done <= 1'b0; byte_val <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_low) begin
        sr <= '0; nbits <= '0; nbytes <= '0;
      end else if (sck_rise) begin
        sr <= full[6:0];
        if (nbits == 3'd7) begin
          nbits     <= '0;
          byte_done <= 1'b1;
          byte_val  <= full;
          if (nbytes == 2'd0) opcode <= full;
          if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
        end else begin
          nbits <= nbits + 3'd1;
        end
      end
    end
endmodule

// File: rtl/spi_eeprom_wtimer.sv
module spi_eeprom_wtimer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cnt <= '0;
    else if (start && cnt == '0)     cnt <= CW'(CYCLES);
    else if (cnt != '0)              cnt <= cnt - 1'b1;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int PAGE  = 1 << PAGE_W;
  localparam logic [ADDR_BITS-1:0] PG_MASK = ADDR_BITS'(PAGE - 1);

  // synchronized pins and edges
  logic [2:0] lvl;
  logic [1:0] ctl_q;
  logic cs_low, cs_rise, sck_rise, sck_fall, si_b;

  spi_eeprom_sync #(.W(3), .STAGES(2), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, si}), .lvl(lvl));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= 2'b10;
    else        ctl_q <= lvl[2:1];

  assign cs_low   = ~lvl[2];
  assign cs_rise  = lvl[2] & ~ctl_q[1];
  assign sck_rise = lvl[1] & ~ctl_q[0];
  assign sck_fall = ~lvl[1] & ctl_q[0];
  assign si_b     = lvl[0];

  // frame tracking
  logic [1:0] nbytes;
  logic [2:0] nbits;
  logic [7:0] opcode, byte_val;
  logic [6:0] part7, cmd7;
  logic       byte_done;

  spi_eeprom_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .sck_rise(sck_rise), .si_b(si_b),
    .nbytes(nbytes), .nbits(nbits), .opcode(opcode), .byte_done(byte_done),
    .byte_val(byte_val), .part7(part7));

  // write cycle timer
  logic wr_start, wr_done, busy;
  spi_eeprom_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .busy(busy), .done(wr_done));

  // state
  logic [7:0]                  mem   [DEPTH];
  logic [7:0]                  pbuf  [PAGE];
  logic [PAGE-1:0]             pvalid;
  logic [ADDR_BITS-1:0]        ptr, rd_nxt;
  logic [ADDR_BITS-PAGE_W-1:0] pend_page;
  logic [USER_BITS-1:0]        user, pend_user;
  logic                        pend_st, wel;
  logic [7:0]                  out_sr, status_byte;
  logic                        out_en;

  // commit and latch decisions at the chip-select rise
  logic commit_w, commit_s, set_wel, clr_wel;
  assign cmd7     = (nbytes == 2'd0) ? part7 : opcode[7:1];
  assign commit_w = cs_rise && opcode == CMD_WRITE && wr_window(nbytes, nbits) && wel && !busy;
  assign commit_s = cs_rise && opcode == CMD_STWR && st_window(nbytes, nbits) && wel && !busy;
  assign wr_start = commit_w | commit_s;
  assign set_wel  = cs_rise && latch_window(nbytes, nbits) && cmd7 == EN_PFX;
  assign clr_wel  = cs_rise && latch_window(nbytes, nbits) && cmd7 == DIS_PFX;

  assign status_byte = {user, wel, busy};
  assign rd_nxt      = (nbytes == 2'd2) ? byte_val[ADDR_BITS-1:0] : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; user <= '0; pend_user <= '0; pend_st <= 1'b0; pend_page <= '0;
    end else begin
      if (wr_done) begin
        wel <= 1'b0;
        if (pend_st) user <= pend_user;
      end
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (wr_start) begin
        pend_st   <= commit_s;
        pend_user <= part7[6:1];
        pend_page <= ptr[ADDR_BITS-1:PAGE_W];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr <= '0; pvalid <= '0; out_sr <= '0; out_en <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      if (wr_done) pvalid <= '0;
      if (!cs_low) begin
        out_en <= 1'b0;
      end else if (byte_done) begin
        if (opcode == CMD_STRD) begin
          out_sr <= status_byte;
          out_en <= 1'b1;
        end else if (opcode == CMD_READ && nbytes >= 2'd2) begin
          ptr    <= rd_nxt;
          out_sr <= mem[rd_nxt];
          out_en <= 1'b1;
        end else if (opcode == CMD_WRITE && !busy) begin
          if (nbytes == 2'd2) begin
            ptr    <= byte_val[ADDR_BITS-1:0];
            pvalid <= '0;
          end else if (nbytes == 2'd3) begin
            pbuf[ptr[PAGE_W-1:0]]   <= byte_val;
            pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
            ptr                     <= page_next(ptr, PG_MASK);
          end
        end
      end else if (sck_fall && nbits != 3'd0) begin
        out_sr <= {out_sr[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_done && !pend_st) begin
      for (int j = 0; j < PAGE; j++)
        if (pvalid[j]) mem[{pend_page, PAGE_W'(j)}] <= pbuf[j];
    end

  assign so = cs_low & out_en & out_sr[7];
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wr_start,
  input logic wr_done,
  input logic wel,
  input logic set_wel,
  input logic cs_low,
  input logic cs_rise,
  input logic so
);
  // R1
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_low |-> !so);
  // R5
  commit_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |-> cs_rise);
  // R8
  latch_needed_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wel));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_start |=> busy);
  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_done && !set_wel |=> !wel);
  // R10
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && !wr_done |=> busy);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_start(wr_start), .wr_done(wr_done),
  .wel(wel), .set_wel(set_wel), .cs_low(cs_low), .cs_rise(cs_rise), .so(so));

// File: tb/spi_eeprom_ctrl_bench.sv
module spi_eeprom_ctrl_bench;
  localparam int WR_CYC = 2000;
  localparam int HALF   = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so;
  always #4 clk = ~clk;

  spi_eeprom_ctrl #(.PAGE_W(4), .WR_CYCLES(WR_CYC)) u_spi_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so));

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  // behavioural reference model
  logic [7:0] m_mem [256];
  bit         m_wel = 0, m_busy = 0, m_pst = 0;
  logic [5:0] m_user = '0, m_puser = '0;
  int         pa[$];
  logic [7:0] pd[$];

  function automatic logic [7:0] m_status();
    return {m_user, m_wel, m_busy};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic mdl_cs_rise(input int nbits);
    logic [7:0] op;
    op = txq[0];
    if (nbits >= 7 && op[7:1] == 7'b0000011) m_wel = 1;
    if (nbits >= 7 && op[7:1] == 7'b0000100) m_wel = 0;
    if (op == 8'h02 && nbits >= 24 && nbits % 8 == 0 && m_wel && !m_busy) begin
      m_busy = 1; m_pst = 0; pa.delete(); pd.delete();
      for (int k = 0; k < (nbits - 16) / 8; k++) begin
        pa.push_back(int'({txq[1][7:4], 4'(int'(txq[1][3:0]) + k)}));
        pd.push_back(txq[2 + k]);
      end
    end
    if (op == 8'h01 && nbits == 15 && m_wel && !m_busy) begin
      m_busy = 1; m_pst = 1; m_puser = txq[1][7:2];
    end
  endtask

  task automatic run_frame(input int nbits);
    logic [7:0] cur, b;
    rxq.delete(); cur = '0;
    cs_n = 1'b0; wait_half();
    for (int i = 0; i < nbits; i++) begin
      b = (i / 8 < txq.size()) ? txq[i / 8] : 8'h00;
      si = b[7 - (i % 8)];
      wait_half();
      cur = {cur[6:0], so};
      sck = 1'b1; wait_half(); sck = 1'b0;
      if (i % 8 == 7) rxq.push_back(cur);
    end
    wait_half();
    cs_n = 1'b1; si = 1'b0;
    wait_half(); wait_half();
    mdl_cs_rise(nbits);
  endtask

  task automatic wait_idle();
    repeat (WR_CYC + 50) @(negedge clk);
    if (m_busy) begin
      if (!m_pst) foreach (pa[k]) m_mem[pa[k]] = pd[k];
      else m_user = m_puser;
      m_wel = 0; m_busy = 0;
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input int nbits);
    txq = '{op};
    run_frame(nbits);
  endtask

  task automatic do_status(input int n, input string tag);
    txq = '{8'h05};
    run_frame(8 + 8 * n);
    for (int i = 0; i < n; i++) chk(rxq[1 + i], m_status(), tag);
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string tag);
    txq = '{8'h03, a};
    run_frame(16 + 8 * n);
    for (int i = 0; i < n; i++) chk(rxq[2 + i], m_mem[(int'(a) + i) % 256], tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    wait_half();
    chk(so, 1'b0, "R1 so idle after reset");
    do_status(2, "R3 status after reset");

    // write without the latch
    txq = '{8'h02, 8'h40, 8'hA5}; run_frame(24); wait_idle();
    do_read(8'h40, 1, "R8 write without latch");

    // latch commands and their edge threshold
    do_cmd(8'h06, 6); do_status(1, "R4 enable with 6 edges");
    do_cmd(8'h06, 7); do_status(1, "R4 enable with 7 edges");
    chk(rxq[1], 8'h02, "R4 latch set");
    do_cmd(8'h08, 8); do_status(1, "R4 disable");
    do_cmd(8'h06, 8); do_status(1, "R4 enable full");

    // cancelled writes
    txq = '{8'h02, 8'h40, 8'h5A}; run_frame(23); wait_idle();
    do_read(8'h40, 1, "R5 cancel at D1");
    txq = '{8'h02, 8'h40, 8'h5A, 8'h77}; run_frame(25); wait_idle();
    do_read(8'h40, 1, "R5 cancel after extra bit");
    do_status(1, "R5 latch kept after cancel");

    // committed write and disturbance during the cycle
    txq = '{8'h02, 8'h40, 8'h5A}; run_frame(24);
    do_status(1, "R9 busy after commit");
    chk(rxq[1], 8'h03, "R9 wip and latch");
    do_read(8'h40, 1, "R11 old data during cycle");
    txq = '{8'h02, 8'h40, 8'hFF}; run_frame(24);
    repeat (5) begin sck = 1'b1; wait_half(); sck = 1'b0; wait_half(); end
    wait_idle();
    do_status(1, "R9 latch cleared at end");
    do_read(8'h40, 1, "R10 committed data kept");
    chk(rxq[2], 8'h5A, "R10 value");
    chk(so, 1'b0, "R1 so idle after read");

    // page write with wrap inside the page
    do_cmd(8'h06, 8);
    txq = '{8'h02, 8'h1E, 8'h11, 8'h22, 8'h33}; run_frame(40); wait_idle();
    do_read(8'h1E, 2, "R6 page bytes");
    do_read(8'h10, 1, "R6 page wrap");
    chk(rxq[2], 8'h33, "R6 wrapped byte");
    do_cmd(8'h06, 8);
    txq = '{8'h02, 8'hFF, 8'hC1, 8'hC2}; run_frame(32); wait_idle();
    do_read(8'hFF, 2, "R2 read wraps array");
    do_read(8'hF0, 1, "R6 wrap to page start");

    // aborted read
    txq = '{8'h03, 8'h1E}; run_frame(12);
    do_status(1, "R2 abort no side effect");
    do_read(8'h1F, 1, "R2 read after abort");

    // status write windows
    do_cmd(8'h06, 8);
    txq = '{8'h01, 8'hA8}; run_frame(14); do_status(1, "R7 cancel at 14");
    txq = '{8'h01, 8'hA8}; run_frame(16); do_status(1, "R7 cancel at 16");
    txq = '{8'h01, 8'hA8}; run_frame(15); do_status(1, "R7 commit at 15");
    wait_idle();
    do_status(1, "R7 user bits stored");
    chk(rxq[1], 8'hA8, "R7 status value");
    txq = '{8'h01, 8'h54}; run_frame(15); wait_idle();
    do_status(3, "R8 status write without latch");

    finished = 1;
    report();
    $finish;
  end
endmodule